// File: doc/BRIEF.md
# DAC Channel Data-Holding Controller

This block is the bus-side control for a two-channel digital-to-analog converter. Each channel owns a single-entry sample register that software or a DMA engine fills. A trigger hands the held sample to the converter and frees the register. The block tracks whether each register is empty and asks for DMA service while there is room. It keeps sticky error flags for lost writes (overflow), starved triggers (underflow) and low-power sleep requests made while a channel runs on the synchronous clock. It also produces a per-channel completion pulse when the converter reports that a conversion has finished.

The converter's finish indication arrives on an input. In synchronous clock mode it is turned into a single-cycle pulse. The flags drive one combined interrupt through a per-flag enable mask and are cleared by writing ones.

Top module: `dac_hold_ctrl`

## Requirements
- R1: After reset both sample registers are empty, `conv_valid`, `done_pulse`, `flags` and `irq` are all zero, `conv_data` is zero, and `dma_req` equals `ch_en`.
- R2: A write (`wr_en[c]`) to an enabled, empty channel stores `wr_data[c*12 +: 12]`, and `dma_req[c]` is low from the clock edge that takes the write.
- R3: A trigger on an enabled channel holding a sample raises `conv_valid[c]` for exactly the next cycle, with that sample on `conv_data[c*12 +: 12]`. The register becomes empty, so `dma_req[c]` goes high again. `conv_data` keeps its value between conversions.
- R4: A write to a full channel with no trigger in the same cycle sets overflow flag `flags[c]`. The written value is discarded and the held sample is kept.
- R5: A trigger on an empty enabled channel sets underflow flag `flags[2+c]`. It presents the previous converted sample again with `conv_valid[c]` high, and the register stays empty.
- R6: When a write and a trigger hit a full channel in the same cycle, the old sample is converted and the new one is held, with no overflow.
- R7: With `sync_mode`=1, a rising edge of `conv_done[c]` gives `done_pulse[c]` high for exactly one cycle, starting at the next clock edge, even if `conv_done[c]` stays high. With `sync_mode`=0, no pulse is produced.
- R8: `sleep_req` sampled while `sync_mode`=1 and any channel is enabled sets sleep-error flag `flags[4]`. With `sync_mode`=0 it sets nothing.
- R9: Every flag stays set until a one is written to the matching bit of `flag_clr`. If a flag's set event and its clear happen in the same cycle, the flag stays set.
- R10: `irq` is the combinational OR of `flags & irq_en`.
- R11: While `ch_en[c]` is low, channel c ignores writes and triggers. It keeps `dma_req[c]` low, sets neither overflow nor underflow, and its register contents survive until it is re-enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 2 | Per-channel enable |
| sync_mode | input | 1 | 1 = converter clocked synchronously to `clk` |
| wr_en | input | 2 | Per-channel write strobe |
| wr_data | input | 24 | Write data, channel c at bits c*12 +: 12 |
| trig | input | 2 | Per-channel conversion trigger |
| conv_done | input | 2 | Converter finish indication per channel |
| sleep_req | input | 1 | Deep-sleep entry request |
| flag_clr | input | 5 | Write-one-to-clear for flags |
| irq_en | input | 5 | Interrupt enable per flag |
| dma_req | output | 2 | Register has space (per channel) |
| conv_valid | output | 2 | Sample handed to converter this cycle |
| conv_data | output | 24 | Sample to converter, channel c at bits c*12 +: 12 |
| done_pulse | output | 2 | One-cycle conversion-finished pulse |
| flags | output | 5 | [1:0] overflow, [3:2] underflow, [4] sleep error |
| irq | output | 1 | Combined enabled-flag interrupt |

## Verification
The assertions assume that reset is low from time zero. They also assume that every input is a synchronous level, stable around each rising edge, so the edge detector on `conv_done` sees one clean value per cycle. They further assume that `ch_en` is treated as the current enable, with no transitional state of its own. The stimulus changes every input on the falling edge and holds it across the following rising edge, and the bench reads the outputs one time unit after that rising edge.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;
   // overflow bits, underflow bits, then one sleep-error bit
   function automatic int flag_width(input int n_ch);
      return 2 * n_ch + 1;
   endfunction
endpackage

// File: rtl/dac_hold_chan.sv
module dac_hold_chan #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              sync_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              trig_i,
   input  logic              done_i,
   output logic              dma_req_o,
   output logic              conv_valid_o,
   output logic [DATA_W-1:0] conv_data_o,
   output logic              done_pulse_o,
   output logic              ovf_set_o,
   output logic              udf_set_o
);
   logic              full_q;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] out_q;
   logic              valid_q;
   logic              done_seen_q;
   logic              done_q;
   logic              wr;
   logic              tg;
   logic              drop;

   assign wr   = en_i & wr_i;
   assign tg   = en_i & trig_i;
   assign drop = wr & full_q & ~tg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q      <= 1'b0;
         hold_q      <= '0;
         out_q       <= '0;
         valid_q     <= 1'b0;
         done_seen_q <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         valid_q <= tg;
         if (tg && full_q) out_q <= hold_q;
         if (wr && !drop) hold_q <= wr_data_i;
         full_q      <= wr | (full_q & ~tg);
         done_seen_q <= done_i;
         done_q      <= done_i & ~done_seen_q & sync_i;
      end
   end

   assign dma_req_o    = en_i & ~full_q;
   assign conv_valid_o = valid_q;
   assign conv_data_o  = out_q;
   assign done_pulse_o = done_q;
   assign ovf_set_o    = drop;
   assign udf_set_o    = tg & ~full_q;

   // R3: a trigger without a write leaves the register empty
   a_r3_trig_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (tg && !wr) |=> !full_q);
   // R4: a dropped write keeps the held sample
   a_r4_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> $stable(hold_q));
   // R5: an underflow repeats the last sample
   a_r5_udf_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (tg && !full_q) |=> (conv_valid_o && $stable(conv_data_o)));
   // R6: simultaneous write and trigger on a full register
   a_r6_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (tg && wr && full_q) |=> (full_q && conv_data_o == $past(hold_q)));
   // R7: the completion pulse lasts one cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse_o |=> !done_pulse_o);
   // R11: a disabled channel starts no conversion
   a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !conv_valid_o);
endmodule

// File: rtl/dac_hold_flags.sv
module dac_hold_flags #(
   parameter int N_CH   = 2,
   parameter int FLAG_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ovf_set_i,
   input  logic [N_CH-1:0]   udf_set_i,
   input  logic              sleep_req_i,
   input  logic              sync_i,
   input  logic [N_CH-1:0]   ch_en_i,
   input  logic [FLAG_W-1:0] clr_i,
   input  logic [FLAG_W-1:0] irq_en_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic              irq_o
);
   logic [FLAG_W-1:0] flags_q;
   logic [FLAG_W-1:0] set_vec;

   assign set_vec = {sleep_req_i & sync_i & (|ch_en_i), udf_set_i, ovf_set_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_vec;
   end

   assign flags_o = flags_q;
   assign irq_o   = |(flags_q & irq_en_i);

   // R9: a set flag is only lost through its clear bit
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flags_q) & ~$past(clr_i) & ~flags_q) == '0));
   // R9: a set event wins over a clear in the same cycle
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
   // R8: sleep request in synchronous mode with a channel running
   a_r8_sleep_err: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req_i && sync_i && (ch_en_i != '0)) |=> flags_q[FLAG_W-1]);
endmodule

// File: rtl/dac_hold_ctrl.sv
module dac_hold_ctrl #(
   parameter int N_CH   = 2,
   parameter int DATA_W = 12,
   localparam int FLAG_W = dac_hold_pkg::flag_width(N_CH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_CH-1:0]        ch_en,
   input  logic                   sync_mode,
   input  logic [N_CH-1:0]        wr_en,
   input  logic [N_CH*DATA_W-1:0] wr_data,
   input  logic [N_CH-1:0]        trig,
   input  logic [N_CH-1:0]        conv_done,
   input  logic                   sleep_req,
   input  logic [FLAG_W-1:0]      flag_clr,
   input  logic [FLAG_W-1:0]      irq_en,
   output logic [N_CH-1:0]        dma_req,
   output logic [N_CH-1:0]        conv_valid,
   output logic [N_CH*DATA_W-1:0] conv_data,
   output logic [N_CH-1:0]        done_pulse,
   output logic [FLAG_W-1:0]      flags,
   output logic                   irq
);
   initial begin
      if (N_CH < 1 || N_CH > 8)
         $fatal(1, "dac_hold_ctrl: N_CH out of range");
      if (DATA_W < 2 || DATA_W > 32)
         $fatal(1, "dac_hold_ctrl: DATA_W out of range");
   end

   logic [N_CH-1:0] ovf_set;
   logic [N_CH-1:0] udf_set;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dac_hold_chan #(.DATA_W(DATA_W)) u_chan (
         .clk          (clk),
         .rst_n        (rst_n),
         .en_i         (ch_en[c]),
         .sync_i       (sync_mode),
         .wr_i         (wr_en[c]),
         .wr_data_i    (wr_data[c*DATA_W +: DATA_W]),
         .trig_i       (trig[c]),
         .done_i       (conv_done[c]),
         .dma_req_o    (dma_req[c]),
         .conv_valid_o (conv_valid[c]),
         .conv_data_o  (conv_data[c*DATA_W +: DATA_W]),
         .done_pulse_o (done_pulse[c]),
         .ovf_set_o    (ovf_set[c]),
         .udf_set_o    (udf_set[c])
      );
   end

   dac_hold_flags #(.N_CH(N_CH), .FLAG_W(FLAG_W)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .ovf_set_i   (ovf_set),
      .udf_set_i   (udf_set),
      .sleep_req_i (sleep_req),
      .sync_i      (sync_mode),
      .ch_en_i     (ch_en),
      .clr_i       (flag_clr),
      .irq_en_i    (irq_en),
      .flags_o     (flags),
      .irq_o       (irq)
   );
endmodule

// File: tb/dac_hold_ctrl_tb.sv
module dac_hold_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ch_en = 2'b11;
   logic        sync_mode = 1'b1;
   logic [1:0]  wr_en = '0;
   logic [23:0] wr_data = '0;
   logic [1:0]  trig = '0;
   logic [1:0]  conv_done = '0;
   logic        sleep_req = 1'b0;
   logic [4:0]  flag_clr = '0;
   logic [4:0]  irq_en = '0;
   logic [1:0]  dma_req;
   logic [1:0]  conv_valid;
   logic [23:0] conv_data;
   logic [1:0]  done_pulse;
   logic [4:0]  flags;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dac_hold_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .sync_mode(sync_mode),
      .wr_en(wr_en), .wr_data(wr_data), .trig(trig), .conv_done(conv_done),
      .sleep_req(sleep_req), .flag_clr(flag_clr), .irq_en(irq_en),
      .dma_req(dma_req), .conv_valid(conv_valid), .conv_data(conv_data),
      .done_pulse(done_pulse), .flags(flags), .irq(irq)
   );

   // {wr, trig, d0, d1, clr, exp_valid, exp_d0, exp_d1, exp_dma, exp_flags}
   localparam int NROW = 11;
   localparam logic [65:0] TBL [NROW] = '{
      {2'b01, 2'b00, 12'h111, 12'h000, 5'b00000, 2'b00, 12'h000, 12'h000, 2'b10, 5'b00000},
      {2'b00, 2'b01, 12'h000, 12'h000, 5'b00000, 2'b01, 12'h111, 12'h000, 2'b11, 5'b00000},
      {2'b00, 2'b10, 12'h000, 12'h000, 5'b00000, 2'b10, 12'h111, 12'h000, 2'b11, 5'b01000},
      {2'b11, 2'b00, 12'h222, 12'h333, 5'b00000, 2'b00, 12'h111, 12'h000, 2'b00, 5'b01000},
      {2'b01, 2'b00, 12'h444, 12'h000, 5'b00000, 2'b00, 12'h111, 12'h000, 2'b00, 5'b01001},
      {2'b01, 2'b01, 12'h555, 12'h000, 5'b00000, 2'b01, 12'h222, 12'h000, 2'b00, 5'b01001},
      {2'b00, 2'b11, 12'h000, 12'h000, 5'b00000, 2'b11, 12'h555, 12'h333, 2'b11, 5'b01001},
      {2'b00, 2'b00, 12'h000, 12'h000, 5'b01001, 2'b00, 12'h555, 12'h333, 2'b11, 5'b00000},
      {2'b00, 2'b01, 12'h000, 12'h000, 5'b00000, 2'b01, 12'h555, 12'h333, 2'b11, 5'b00100},
      {2'b00, 2'b01, 12'h000, 12'h000, 5'b00100, 2'b01, 12'h555, 12'h333, 2'b11, 5'b00100},
      {2'b00, 2'b00, 12'h000, 12'h000, 5'b00100, 2'b00, 12'h555, 12'h333, 2'b11, 5'b00000}
   };
   localparam string TAG [NROW] = '{"R2", "R3", "R5", "R2", "R4", "R6",
                                    "R3", "R9", "R5", "R9", "R9"};

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic idle;
      @(negedge clk);
      wr_en = '0; trig = '0; flag_clr = '0; sleep_req = 1'b0; conv_done = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "dma", 32'(dma_req), 32'(2'b11));
      check("R1", "flags", 32'(flags), 32'd0);
      check("R1", "valid/done", 32'({conv_valid, done_pulse}), 32'd0);
      @(negedge clk) rst_n = 1'b1;
      step();
      check("R1", "data", 32'(conv_data), 32'd0);
      check("R10", "irq", 32'(irq), 32'd0);

      for (int r = 0; r < NROW; r++) begin
         @(negedge clk);
         wr_en    = TBL[r][65:64];
         trig     = TBL[r][63:62];
         wr_data  = {TBL[r][49:38], TBL[r][61:50]};
         flag_clr = TBL[r][37:33];
         step();
         check(TAG[r], "valid", 32'(conv_valid), 32'(TBL[r][32:31]));
         check(TAG[r], "data", 32'(conv_data), 32'({TBL[r][18:7], TBL[r][30:19]}));
         check(TAG[r], "dma", 32'(dma_req), 32'(TBL[r][6:5]));
         check(TAG[r], "flags", 32'(flags), 32'(TBL[r][4:0]));
      end
      idle();

      // R7: completion pulse in synchronous mode, input held high
      @(negedge clk) conv_done = 2'b01;
      step();
      check("R7", "pulse on", 32'(done_pulse), 32'(2'b01));
      step();
      check("R7", "pulse off", 32'(done_pulse), 32'd0);
      @(negedge clk) conv_done = 2'b00; sync_mode = 1'b0;
      @(negedge clk) conv_done = 2'b10;
      step();
      check("R7", "no pulse async", 32'(done_pulse), 32'd0);
      step();
      check("R7", "no pulse async later", 32'(done_pulse), 32'd0);
      idle();

      // R8: sleep request ignored in asynchronous mode
      @(negedge clk) sleep_req = 1'b1;
      step();
      check("R8", "async sleep", 32'(flags), 32'd0);
      @(negedge clk) sync_mode = 1'b1;
      step();
      check("R8", "sync sleep", 32'(flags), 32'(5'b10000));
      idle();
      // R10: interrupt follows the enable mask
      @(negedge clk) irq_en = 5'b01111;
      #1 check("R10", "masked", 32'(irq), 32'd0);
      @(negedge clk) irq_en = 5'b10000;
      #1 check("R10", "enabled", 32'(irq), 32'd1);
      @(negedge clk) flag_clr = 5'b10000;
      step();
      check("R9", "sleep cleared", 32'(flags), 32'd0);
      check("R10", "irq cleared", 32'(irq), 32'd0);
      idle();

      // R11: disabled channel ignores writes and triggers
      @(negedge clk) ch_en = 2'b01;
      #1 check("R11", "dma low", 32'(dma_req), 32'(2'b01));
      @(negedge clk) wr_en = 2'b10; wr_data = {12'h777, 12'h000};
      step();
      @(negedge clk) wr_en = 2'b00; trig = 2'b10;
      step();
      check("R11", "no conversion", 32'(conv_valid), 32'd0);
      check("R11", "no flags", 32'(flags), 32'd0);
      check("R11", "data kept", 32'(conv_data), 32'({12'h333, 12'h555}));
      idle();
      @(negedge clk) ch_en = 2'b11;
      #1 check("R11", "still empty", 32'(dma_req), 32'(2'b11));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule